// File: doc/BRIEF.md
# Configurable True Dual-Port RAM

This block is an 8192-bit memory reached through two independent ports, A and B. Each port can read and write on its own clock, and each port's data width is chosen by a parameter from 1, 2, 4, 8 or 16 bits. The address width follows from the data width, so the two ports may see the same storage with different shapes. For example, one port can address it as 1024 bytes while the other addresses it as 512 halfwords.

Every request input of a port (select bits, write/read flag, address and write data) is captured in a register on the port's input clock. The read output is set per port by a parameter. It is either a register on the port's output clock, or a combinational view of the captured request. Each port has two clock domains: one for its input registers and one for its output register. Each domain has its own clock, clock enable and reset. The resets are asynchronous, and a global reset is ORed with each of them. Parameters can invert the clock, enable and reset polarities of a port.

Top module: `tdp_ram`

## Requirements
- R1: A port of data width W (1, 2, 4, 8 or 16) has 13 − log2(W) address bits and reaches all 8192 bits of storage. A value written at any address, including the highest one, is read back unchanged through the same port.
- R2: Address n of a W-bit port holds storage bits n·W to n·W+W−1, with data bit 0 at the lowest storage bit. A write through one port is therefore seen through the other port at the corresponding bits. A write changes only its own W bits.
- R3: Requests are taken at an active input clock edge. A port with a registered output presents the read result after the next active output clock edge. A port with a combinational output presents it right after the capturing edge.
- R4: An access takes place only when the captured 2-bit select equals the port's match parameter (defaults: A 2'b01, B 2'b10). On a mismatch, no write is made and the read output keeps its last value.
- R5: The input registers change only when the input enable is at its active level. The output register changes only when the output enable is at its active level. By default, port A enables are active-high and port B enables are active-low (1 = hold).
- R6: Resets act asynchronously. The effective reset of a domain is the global reset (active-high) ORed with the port's reset for that domain. Port resets are active-high on A and active-low on B by default. An input reset clears the captured request. An output reset clears the read output to zero while the port is idle. No reset alters the stored data.
- R7: During a write, the read output of the writing port shows the newly written data.
- R8: When one port reads a location that the other port writes in the same cycle, the read returns the previous contents. The two ports never write the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_rst | input | 1 | Global asynchronous reset, active-high, ORed into every domain |
| a_clk | input | 1 | Port A input-register clock |
| a_ce | input | 1 | Port A input-register enable |
| a_rst | input | 1 | Port A input-register reset |
| a_oclk | input | 1 | Port A output-register clock |
| a_oce | input | 1 | Port A output-register enable |
| a_orst | input | 1 | Port A output-register reset |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_cs | input | 2 | Port A select bits |
| a_addr | input | 13−log2(A_DW) | Port A address |
| a_wdata | input | A_DW | Port A write data |
| a_rdata | output | A_DW | Port A read data |
| b_clk | input | 1 | Port B input-register clock |
| b_ce | input | 1 | Port B input-register enable |
| b_rst | input | 1 | Port B input-register reset |
| b_oclk | input | 1 | Port B output-register clock |
| b_oce | input | 1 | Port B output-register enable |
| b_orst | input | 1 | Port B output-register reset |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_cs | input | 2 | Port B select bits |
| b_addr | input | 13−log2(B_DW) | Port B address |
| b_wdata | input | B_DW | Port B write data |
| b_rdata | output | B_DW | Port B read data |

## Verification
The assertions take for granted that the two ports never commit writes to overlapping bits of one 16-bit storage word in the same cycle. That case is flagged rather than resolved. They also take for granted that enables and resets are driven away from the clock edges they qualify. The bench drives every input at the falling clock edge, and it samples there too. It orders its cross-port scenarios so that a simultaneous pair is always a read on one port and a write on the other. It never issues two writes at once.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    localparam int TOTAL_BITS = 8192;
    localparam int WORD_BITS  = 16;
    localparam int WORD_COUNT = TOTAL_BITS / WORD_BITS;
    localparam int IDX_W      = $clog2(WORD_COUNT);
    localparam int OFF_W      = $clog2(WORD_BITS);

    typedef logic [WORD_BITS-1:0] word_t;
    typedef logic [IDX_W-1:0]     idx_t;
    typedef logic [OFF_W-1:0]     off_t;

    // address bits needed by a port of the given data width
    function automatic int addr_bits(input int dw);
        return $clog2(TOTAL_BITS / dw);
    endfunction

endpackage

// File: rtl/tdp_bank.sv
// One half of the XOR-coded storage. Only its own port writes it; the
// stored word is the written data XOR the partner bank at that index, so
// XOR of both banks always yields the latest value of every bit.
module tdp_bank
    import tdp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  wr_idx,
    input  word_t wr_mask,
    input  word_t wr_word,
    input  word_t partner_word,
    input  idx_t  peer_idx,
    output word_t own_rd,
    output word_t peer_rd
);

    word_t mem [WORD_COUNT];
    word_t merged;

    assign own_rd  = mem[wr_idx];
    assign peer_rd = mem[peer_idx];

    always_comb begin
        merged = (own_rd & ~wr_mask) | ((wr_word ^ partner_word) & wr_mask);
    end

    always_ff @(posedge clk) begin
        if (we && !rst) begin
            mem[wr_idx] <= merged;
        end
    end

    // checker support: the word last addressed, seen one edge later
    idx_t  chk_idx;
    word_t chk_now;
    always_ff @(posedge clk) begin
        chk_idx <= wr_idx;
    end
    assign chk_now = mem[chk_idx];

    // R2: a commit touches only the lane bits of its word
    assert_lane_only_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> ((chk_now & ~$past(wr_mask)) == ($past(own_rd) & ~$past(wr_mask))));

endmodule

// File: rtl/tdp_port.sv
// Request capture, lane decode and read-output path of one port.
module tdp_port
    import tdp_pkg::*;
#(
    parameter int         DW       = 8,
    parameter bit         OUT_REG  = 1'b1,
    parameter logic [1:0] CS_MATCH = 2'b01,
    parameter bit         CLK_INV  = 1'b0,
    parameter bit         CE_INV   = 1'b0,
    parameter bit         RST_INV  = 1'b0,
    localparam int        AW       = addr_bits(DW)
)(
    input  logic          glb_rst,
    input  logic          clk_in,
    input  logic          ce_in,
    input  logic          rst_in,
    input  logic          clk_out,
    input  logic          ce_out,
    input  logic          rst_out,
    input  logic          we,
    input  logic [1:0]    cs,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  word_t         rd_word,
    output logic          acc_clk,
    output logic          acc_rst,
    output logic          acc_go,
    output idx_t          acc_idx,
    output word_t         acc_mask,
    output word_t         acc_wword
);

    localparam int    LANES     = WORD_BITS / DW;
    localparam int    LB        = $clog2(LANES);
    localparam word_t LANE_ONES = word_t'((32'd1 << DW) - 32'd1);

    typedef struct packed {
        logic [1:0]    cs;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic [DW-1:0] data;
    } out_t;

    logic clk_i_e, clk_o_e, ce_i_e, ce_o_e, rst_i_e, rst_o_e;
    assign clk_i_e = clk_in ^ CLK_INV;
    assign clk_o_e = clk_out ^ CLK_INV;
    assign ce_i_e  = ce_in ^ CE_INV;
    assign ce_o_e  = ce_out ^ CE_INV;
    assign rst_i_e = glb_rst | (rst_in ^ RST_INV);
    assign rst_o_e = glb_rst | (rst_out ^ RST_INV);

    req_t req_d, req_q;
    out_t out_d, out_q;

    logic          hit;
    off_t          off;
    logic [DW-1:0] live;

    assign hit  = (req_q.cs == CS_MATCH);
    assign off  = off_t'((int'(req_q.addr) % LANES) * DW);
    assign live = req_q.we ? req_q.wdata : DW'(rd_word >> off);

    // input side: next captured request
    always_comb begin
        req_d = req_q;
        if (ce_i_e) begin
            req_d.cs    = cs;
            req_d.we    = we;
            req_d.addr  = addr;
            req_d.wdata = wdata;
        end
    end

    always_ff @(posedge clk_i_e or posedge rst_i_e) begin
        if (rst_i_e) req_q <= '0;
        else         req_q <= req_d;
    end

    // output side: result register, also the hold value of the direct path
    always_comb begin
        out_d = out_q;
        if (ce_o_e && hit) begin
            out_d.data = live;
        end
    end

    always_ff @(posedge clk_o_e or posedge rst_o_e) begin
        if (rst_o_e) out_q <= '0;
        else         out_q <= out_d;
    end

    generate
        if (OUT_REG) begin : g_sync_out
            assign rdata = out_q.data;
        end else begin : g_direct_out
            assign rdata = hit ? live : out_q.data;
        end
    endgenerate

    assign acc_clk   = clk_i_e;
    assign acc_rst   = rst_i_e;
    assign acc_go    = hit && req_q.we && ce_i_e;
    assign acc_idx   = idx_t'(req_q.addr >> LB);
    assign acc_mask  = LANE_ONES << off;
    assign acc_wword = word_t'(req_q.wdata) << off;

    // R5: a disabled input edge leaves the captured request as it was
    assert_in_enable_R5: assert property (@(posedge clk_i_e) disable iff (rst_i_e)
        !ce_i_e |=> $stable(req_q));

    // R5: a disabled output edge leaves the result as it was
    assert_out_enable_R5: assert property (@(posedge clk_o_e) disable iff (rst_o_e)
        !ce_o_e |=> $stable(out_q));

    // R4: without a select match the result holds
    assert_hold_on_miss_R4: assert property (@(posedge clk_o_e) disable iff (rst_o_e)
        (ce_o_e && !hit) |=> $stable(out_q));

    // R7: an enabled write shows its own data at the output side
    assert_write_through_R7: assert property (@(posedge clk_o_e) disable iff (rst_o_e)
        (ce_o_e && hit && req_q.we) |=> (out_q.data == $past(req_q.wdata)));

    // R6: while the input reset holds, nothing is captured
    assert_inreg_reset_R6: assert property (@(posedge clk_i_e)
        rst_i_e |-> (req_q == '0));

endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
    import tdp_pkg::*;
#(
    parameter int         A_DW       = 8,
    parameter bit         A_OUT_REG  = 1'b1,
    parameter logic [1:0] A_CS_MATCH = 2'b01,
    parameter bit         A_CLK_INV  = 1'b0,
    parameter bit         A_CE_INV   = 1'b0,
    parameter bit         A_RST_INV  = 1'b0,
    parameter int         B_DW       = 16,
    parameter bit         B_OUT_REG  = 1'b0,
    parameter logic [1:0] B_CS_MATCH = 2'b10,
    parameter bit         B_CLK_INV  = 1'b0,
    parameter bit         B_CE_INV   = 1'b1,
    parameter bit         B_RST_INV  = 1'b1,
    localparam int        A_AW       = addr_bits(A_DW),
    localparam int        B_AW       = addr_bits(B_DW)
)(
    input  logic            glb_rst,
    input  logic            a_clk,
    input  logic            a_ce,
    input  logic            a_rst,
    input  logic            a_oclk,
    input  logic            a_oce,
    input  logic            a_orst,
    input  logic            a_we,
    input  logic [1:0]      a_cs,
    input  logic [A_AW-1:0] a_addr,
    input  logic [A_DW-1:0] a_wdata,
    output logic [A_DW-1:0] a_rdata,
    input  logic            b_clk,
    input  logic            b_ce,
    input  logic            b_rst,
    input  logic            b_oclk,
    input  logic            b_oce,
    input  logic            b_orst,
    input  logic            b_we,
    input  logic [1:0]      b_cs,
    input  logic [B_AW-1:0] b_addr,
    input  logic [B_DW-1:0] b_wdata,
    output logic [B_DW-1:0] b_rdata
);

    logic  a_wclk, a_wrst, a_go, b_wclk, b_wrst, b_go;
    idx_t  a_idx, b_idx;
    word_t a_mask, b_mask, a_wword, b_wword, a_word, b_word;

    tdp_port #(
        .DW(A_DW), .OUT_REG(A_OUT_REG), .CS_MATCH(A_CS_MATCH),
        .CLK_INV(A_CLK_INV), .CE_INV(A_CE_INV), .RST_INV(A_RST_INV)
    ) u_port_a (
        .glb_rst(glb_rst), .clk_in(a_clk), .ce_in(a_ce), .rst_in(a_rst),
        .clk_out(a_oclk), .ce_out(a_oce), .rst_out(a_orst),
        .we(a_we), .cs(a_cs), .addr(a_addr), .wdata(a_wdata), .rdata(a_rdata),
        .rd_word(a_word), .acc_clk(a_wclk), .acc_rst(a_wrst), .acc_go(a_go),
        .acc_idx(a_idx), .acc_mask(a_mask), .acc_wword(a_wword)
    );

    tdp_port #(
        .DW(B_DW), .OUT_REG(B_OUT_REG), .CS_MATCH(B_CS_MATCH),
        .CLK_INV(B_CLK_INV), .CE_INV(B_CE_INV), .RST_INV(B_RST_INV)
    ) u_port_b (
        .glb_rst(glb_rst), .clk_in(b_clk), .ce_in(b_ce), .rst_in(b_rst),
        .clk_out(b_oclk), .ce_out(b_oce), .rst_out(b_orst),
        .we(b_we), .cs(b_cs), .addr(b_addr), .wdata(b_wdata), .rdata(b_rdata),
        .rd_word(b_word), .acc_clk(b_wclk), .acc_rst(b_wrst), .acc_go(b_go),
        .acc_idx(b_idx), .acc_mask(b_mask), .acc_wword(b_wword)
    );

    logic [1:0] bk_clk, bk_rst, bk_we;
    idx_t       bk_idx   [2];
    word_t      bk_mask  [2];
    word_t      bk_wword [2];
    word_t      own_rd   [2];
    word_t      peer_rd  [2];

    assign bk_clk      = {b_wclk, a_wclk};
    assign bk_rst      = {b_wrst, a_wrst};
    assign bk_we       = {b_go, a_go};
    assign bk_idx[0]   = a_idx;
    assign bk_idx[1]   = b_idx;
    assign bk_mask[0]  = a_mask;
    assign bk_mask[1]  = b_mask;
    assign bk_wword[0] = a_wword;
    assign bk_wword[1] = b_wword;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        tdp_bank u_bank (
            .clk(bk_clk[g]), .rst(bk_rst[g]), .we(bk_we[g]),
            .wr_idx(bk_idx[g]), .wr_mask(bk_mask[g]), .wr_word(bk_wword[g]),
            .partner_word(peer_rd[1-g]), .peer_idx(bk_idx[1-g]),
            .own_rd(own_rd[g]), .peer_rd(peer_rd[g])
        );
    end

    // each port's view is the XOR of both banks at its own word
    assign a_word = own_rd[0] ^ peer_rd[1];
    assign b_word = own_rd[1] ^ peer_rd[0];

    // R8: the two ports never commit to the same bit in one cycle
    assert_no_write_overlap_R8: assert property (@(posedge a_wclk) disable iff (a_wrst)
        !(a_go && b_go && (a_idx == b_idx) && ((a_mask & b_mask) != '0)));

endmodule

// File: tb/tdp_ram_test.sv
module tdp_ram_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        glb_rst;
    logic        a_ce, a_rst, a_oce, a_orst, a_we;
    logic [1:0]  a_cs;
    logic [9:0]  a_addr;
    logic [7:0]  a_wdata, a_rdata;
    logic        b_ce, b_rst, b_oce, b_orst, b_we;
    logic [1:0]  b_cs;
    logic [8:0]  b_addr;
    logic [15:0] b_wdata, b_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdp_ram uut (
        .glb_rst(glb_rst),
        .a_clk(clk), .a_ce(a_ce), .a_rst(a_rst), .a_oclk(clk), .a_oce(a_oce), .a_orst(a_orst),
        .a_we(a_we), .a_cs(a_cs), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_clk(clk), .b_ce(b_ce), .b_rst(b_rst), .b_oclk(clk), .b_oce(b_oce), .b_orst(b_orst),
        .b_we(b_we), .b_cs(b_cs), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // A: registered output, result valid two falling edges after presenting
    task automatic a_access(input logic w, input logic [9:0] ad, input logic [7:0] d,
                            input logic [1:0] c);
        @(negedge clk); a_we = w; a_addr = ad; a_wdata = d; a_cs = c;
        @(negedge clk); a_we = 1'b0; a_cs = 2'b00;
        @(negedge clk);
    endtask

    // B: direct output, sampled one falling edge after presenting
    task automatic b_access(input logic w, input logic [8:0] ad, input logic [15:0] d,
                            input logic [1:0] c, output logic [15:0] live);
        @(negedge clk); b_we = w; b_addr = ad; b_wdata = d; b_cs = c;
        @(negedge clk); live = b_rdata; b_we = 1'b0; b_cs = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R6 reset A output", 16'(a_rdata), 16'h0000);
        check("R6 reset B output", b_rdata, 16'h0000);
        glb_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_basic;
        logic [15:0] v;
        a_access(1'b1, 10'd0, 8'h5A, 2'b01);
        check("R7 A write shows data", 16'(a_rdata), 16'h005A);
        a_access(1'b1, 10'd1023, 8'hC3, 2'b01);
        a_access(1'b0, 10'd0, 8'h00, 2'b01);
        check("R1 A readback addr 0", 16'(a_rdata), 16'h005A);
        a_access(1'b0, 10'd1023, 8'h00, 2'b01);
        check("R1 A readback top addr", 16'(a_rdata), 16'h00C3);
        b_access(1'b1, 9'd511, 16'h1234, 2'b10, v);
        check("R7 B write shows data", v, 16'h1234);
        b_access(1'b0, 9'd511, 16'h0000, 2'b10, v);
        check("R1 B readback top addr", v, 16'h1234);
        a_access(1'b0, 10'd1022, 8'h00, 2'b01);
        check("R2 A low byte of B top word", 16'(a_rdata), 16'h0034);
    endtask

    task automatic t_map;
        logic [15:0] v;
        a_access(1'b1, 10'd6, 8'h11, 2'b01);
        a_access(1'b1, 10'd7, 8'h22, 2'b01);
        b_access(1'b0, 9'd3, 16'h0000, 2'b10, v);
        check("R2 B word from two A bytes", v, 16'h2211);
        b_access(1'b1, 9'd10, 16'hBEEF, 2'b10, v);
        a_access(1'b0, 10'd20, 8'h00, 2'b01);
        check("R2 A low byte of B word", 16'(a_rdata), 16'h00EF);
        a_access(1'b0, 10'd21, 8'h00, 2'b01);
        check("R2 A high byte of B word", 16'(a_rdata), 16'h00BE);
        a_access(1'b1, 10'd21, 8'h77, 2'b01);
        b_access(1'b0, 9'd10, 16'h0000, 2'b10, v);
        check("R2 narrow write keeps other lane", v, 16'h77EF);
    endtask

    task automatic t_timing;
        // A currently shows 0x77 from its last write
        @(negedge clk); a_we = 1'b0; a_addr = 10'd6; a_cs = 2'b01;
        @(negedge clk); a_cs = 2'b00;
        check("R3 A not yet updated after capture", 16'(a_rdata), 16'h0077);
        @(negedge clk);
        check("R3 A updated after output edge", 16'(a_rdata), 16'h0011);
        @(negedge clk); b_we = 1'b0; b_addr = 9'd10; b_cs = 2'b10;
        @(negedge clk);
        check("R3 B direct output after capture", b_rdata, 16'h77EF);
        b_cs = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_select;
        logic [15:0] v;
        a_access(1'b1, 10'd6, 8'h99, 2'b11);
        check("R4 A mismatch write holds output", 16'(a_rdata), 16'h0011);
        a_access(1'b0, 10'd7, 8'h00, 2'b10);
        check("R4 A mismatch read holds output", 16'(a_rdata), 16'h0011);
        a_access(1'b0, 10'd6, 8'h00, 2'b01);
        check("R4 A mismatch write not stored", 16'(a_rdata), 16'h0011);
        b_access(1'b0, 9'd3, 16'h0000, 2'b10, v);
        b_access(1'b1, 9'd3, 16'hFFFF, 2'b01, v);
        check("R4 B mismatch holds output", v, 16'h2211);
        b_access(1'b0, 9'd3, 16'h0000, 2'b10, v);
        check("R4 B mismatch write not stored", v, 16'h2211);
    endtask

    task automatic t_enable;
        logic [15:0] v;
        @(negedge clk); a_ce = 1'b0; a_we = 1'b1; a_addr = 10'd6; a_wdata = 8'h55; a_cs = 2'b01;
        @(negedge clk); a_we = 1'b0; a_cs = 2'b00; a_ce = 1'b1;
        @(negedge clk);
        a_access(1'b0, 10'd6, 8'h00, 2'b01);
        check("R5 A write with input enable low ignored", 16'(a_rdata), 16'h0011);
        a_oce = 1'b0;
        a_access(1'b0, 10'd7, 8'h00, 2'b01);
        check("R5 A output enable low holds", 16'(a_rdata), 16'h0011);
        a_oce = 1'b1;
        a_access(1'b0, 10'd7, 8'h00, 2'b01);
        check("R5 A output enable restored", 16'(a_rdata), 16'h0022);
        b_ce = 1'b1;
        b_access(1'b1, 9'd3, 16'h0F0F, 2'b10, v);
        b_ce = 1'b0;
        check("R5 B active-low enable blocks capture", v, 16'h2211);
        b_access(1'b0, 9'd3, 16'h0000, 2'b10, v);
        check("R5 B blocked write not stored", v, 16'h2211);
    endtask

    task automatic t_resets;
        logic [15:0] v;
        @(negedge clk); a_orst = 1'b1;
        @(negedge clk);
        check("R6 A output reset clears", 16'(a_rdata), 16'h0000);
        a_orst = 1'b0;
        a_access(1'b0, 10'd7, 8'h00, 2'b01);
        check("R6 A data kept over output reset", 16'(a_rdata), 16'h0022);
        @(negedge clk); glb_rst = 1'b1;
        @(negedge clk);
        check("R6 global reset clears A", 16'(a_rdata), 16'h0000);
        check("R6 global reset clears B", b_rdata, 16'h0000);
        glb_rst = 1'b0;
        b_access(1'b0, 9'd3, 16'h0000, 2'b10, v);
        check("R6 B data kept over global reset", v, 16'h2211);
        a_access(1'b0, 10'd6, 8'h00, 2'b01);
        check("R6 A data kept over global reset", 16'(a_rdata), 16'h0011);
        @(negedge clk); b_rst = 1'b0; b_we = 1'b0; b_addr = 9'd10; b_cs = 2'b10;
        @(negedge clk);
        check("R6 B active-low input reset blocks capture", b_rdata, 16'h2211);
        b_cs = 2'b00; b_rst = 1'b1;
        @(negedge clk); b_orst = 1'b0;
        @(negedge clk);
        check("R6 B active-low output reset clears", b_rdata, 16'h0000);
        b_orst = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_cross;
        logic [15:0] v;
        a_access(1'b1, 10'd40, 8'h3C, 2'b01);
        // A reads byte 40 while B writes word 20 in the same cycle
        @(negedge clk);
        a_we = 1'b0; a_addr = 10'd40; a_cs = 2'b01;
        b_we = 1'b1; b_addr = 9'd20; b_wdata = 16'hA5C3; b_cs = 2'b10;
        @(negedge clk);
        a_cs = 2'b00; b_we = 1'b0; b_cs = 2'b00;
        @(negedge clk);
        check("R8 A read during B write returns old", 16'(a_rdata), 16'h003C);
        a_access(1'b0, 10'd40, 8'h00, 2'b01);
        check("R8 A sees B write afterwards", 16'(a_rdata), 16'h00C3);
        // B reads word 20 while A writes byte 41 in the same cycle
        @(negedge clk);
        a_we = 1'b1; a_addr = 10'd41; a_wdata = 8'h66; a_cs = 2'b01;
        b_we = 1'b0; b_addr = 9'd20; b_cs = 2'b10;
        @(negedge clk);
        check("R8 B read during A write returns old", b_rdata, 16'hA5C3);
        a_we = 1'b0; a_cs = 2'b00; b_cs = 2'b00;
        @(negedge clk);
        check("R8 B held old after A commit", b_rdata, 16'hA5C3);
        b_access(1'b0, 9'd20, 16'h0000, 2'b10, v);
        check("R8 B sees A write afterwards", v, 16'h66C3);
    endtask

    initial begin
        glb_rst = 1'b1;
        a_ce = 1'b1; a_rst = 1'b0; a_oce = 1'b1; a_orst = 1'b0;
        a_we = 1'b0; a_cs = 2'b00; a_addr = '0; a_wdata = '0;
        b_ce = 1'b0; b_rst = 1'b1; b_oce = 1'b0; b_orst = 1'b1;
        b_we = 1'b0; b_cs = 2'b00; b_addr = '0; b_wdata = '0;
        repeat (3) @(negedge clk);
        t_reset;
        t_basic;
        t_map;
        t_timing;
        t_select;
        t_enable;
        t_resets;
        t_cross;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..R8 run incomplete): actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule